// File: doc/BRIEF.md
# Sixteen-Channel DAC Command Sequencer

This block sits in front of a bank of digital-to-analog channels and turns 18-bit commands received on a three-wire serial port into per-channel code updates. The port has a serial clock, a data line and an active-low frame select. Each channel holds a 14-bit fine code. A coarse write places a 12-bit code in the upper bits of the fine code. Relative commands move a channel up or down in quarter-LSB units, which gives the channel a finer 14-bit resolution.

Each accepted command pulls an active-low busy line low for an update time that depends on the command type. The update time is set by two cycle-count parameters. While busy is low the serial clock is ignored. When the time expires, the new code appears on the addressed channel, a one-cycle update strobe fires, and busy returns high. All channel codes are brought out as one flat bus for the downstream converters.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset every channel holds mid-scale code 0x2000, `busy_n` is high and `upd_stb` is low.
- R2: A frame is the bits sampled on falling `sclk` edges while `sync_n` is low, MSB first. Word bits [17:16] hold the operation, bits [15:12] the channel and bits [11:0] the operand. The frame is evaluated when `sync_n` rises.
- R3: Operation 00 loads operand<<2 into the addressed channel, so 12-bit code C becomes fine code 4*C.
- R4: Operation 01 adds operand bits [6:0] to the addressed channel's fine code, saturating at 0x3FFF. Operand bits [11:7] are disregarded.
- R5: Operation 10 subtracts operand bits [6:0] from the addressed channel's fine code, saturating at 0x0000.
- R6: An accepted load holds `busy_n` low for exactly WRITE_CYCLES clock cycles, and an accepted step holds it low for exactly STEP_CYCLES cycles.
- R7: The addressed code changes in the same cycle that `busy_n` returns high. In that cycle `upd_stb` is high for one cycle and `upd_chan` names the channel. No other channel changes.
- R8: Operation 11 changes no code, does not lower `busy_n` and produces no strobe.
- R9: Falling `sclk` edges that arrive while `busy_n` is low are not counted or shifted, so a frame overlapping the busy window falls short and is discarded.
- R10: A frame with other than exactly 18 falling edges is discarded. No code changes, no busy and no strobe result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial lines are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| din | input | 1 | Serial data, MSB first |
| sync_n | input | 1 | Active-low frame select |
| busy_n | output | 1 | Low while an update is in progress |
| upd_stb | output | 1 | One-cycle pulse when a channel code is updated |
| upd_chan | output | 4 | Channel updated with the current strobe |
| chan_codes | output | 224 | Sixteen 14-bit codes, channel n at bits [14n+13:14n] |

## Verification
The bench keeps the sixteen channels and the 12-bit operand width, but shortens the update times to WRITE_CYCLES = 20 and STEP_CYCLES = 5. The short windows let every channel be written and timed in turn. The 20-cycle window is still long enough to swallow several serial clock edges, so the lockout case is covered. With the small step window the bench can apply many step sizes and reach both saturation bounds with exact cycle counts.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_UP   = 2'b01,
    OP_DOWN = 2'b10,
    OP_NONE = 2'b11
  } dac_op_e;

  localparam int OP_W = 2;

endpackage

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int FRAME_BITS = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  din,
  input  logic                  sync_n,
  input  logic                  lock,
  output logic                  frame_ok,
  output logic [FRAME_BITS-1:0] frame_word
);
  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int CNT_SAT = FRAME_BITS + 1;

  logic             sclk_q;
  logic             sync_q;
  logic [CNT_W-1:0] edge_cnt;
  logic             edge_take;
  logic             sync_rise;

  assign edge_take = sclk_q && !sclk && !sync_n && !lock;
  assign sync_rise = !sync_q && sync_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      sync_q     <= 1'b1;
      edge_cnt   <= '0;
      frame_word <= '0;
      frame_ok   <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      sync_q   <= sync_n;
      frame_ok <= sync_rise && (edge_cnt == CNT_W'(FRAME_BITS));
      if (sync_n) begin
        edge_cnt <= '0;
      end else if (edge_take) begin
        frame_word <= {frame_word[FRAME_BITS-2:0], din};
        if (edge_cnt != CNT_W'(CNT_SAT)) edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_busy_timer.sv
module dac_busy_timer #(
  parameter int TMR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TMR_W-1:0] len,
  output logic             busy,
  output logic             done
);
  logic [TMR_W-1:0] remain;

  assign busy = (remain != '0);
  assign done = (remain == TMR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)          remain <= '0;
    else if (start)      remain <= len;
    else if (remain != '0) remain <= remain - 1'b1;
  end
endmodule

// File: rtl/dac_cmd_exec.sv
module dac_cmd_exec
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH       = 16,
  parameter int AW           = 4,
  parameter int CODE_W       = 12,
  parameter int FRAC_W       = 2,
  parameter int STEP_W       = 7,
  parameter int FRAME_BITS   = 18,
  parameter int TMR_W        = 12,
  parameter int WRITE_CYCLES = 2500,
  parameter int STEP_CYCLES  = 100
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_ok,
  input  logic [FRAME_BITS-1:0]          frame_word,
  input  logic [NUM_CH*(CODE_W+FRAC_W)-1:0] cur_codes,
  input  logic                           tmr_done,
  output logic                           cmd_start,
  output logic [TMR_W-1:0]               cmd_len,
  output logic                           wr_en,
  output logic [AW-1:0]                  wr_addr,
  output logic [CODE_W+FRAC_W-1:0]       wr_data,
  output logic                           upd_stb,
  output logic [AW-1:0]                  upd_chan
);
  localparam int FINE_W = CODE_W + FRAC_W;
  localparam logic [FINE_W-1:0] FINE_MAX = '1;

  function automatic logic [FINE_W-1:0] coarse_to_fine(input logic [CODE_W-1:0] c);
    return {c, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [FINE_W-1:0] step_up(input logic [FINE_W-1:0] cur,
                                                input logic [STEP_W-1:0] s);
    logic [FINE_W:0] sum;
    sum = {1'b0, cur} + (FINE_W+1)'(s);
    return sum[FINE_W] ? FINE_MAX : sum[FINE_W-1:0];
  endfunction

  function automatic logic [FINE_W-1:0] step_down(input logic [FINE_W-1:0] cur,
                                                  input logic [STEP_W-1:0] s);
    return (cur < FINE_W'(s)) ? '0 : cur - FINE_W'(s);
  endfunction

  dac_op_e          in_op;
  dac_op_e          cmd_op;
  logic [AW-1:0]    cmd_addr;
  logic [CODE_W-1:0] cmd_data;
  logic [FINE_W-1:0] cur_sel;

  assign in_op     = dac_op_e'(frame_word[FRAME_BITS-1 -: OP_W]);
  assign cmd_start = frame_ok && (in_op != OP_NONE);
  assign cmd_len   = (in_op == OP_LOAD) ? TMR_W'(WRITE_CYCLES) : TMR_W'(STEP_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_op   <= OP_NONE;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else if (cmd_start) begin
      cmd_op   <= in_op;
      cmd_addr <= frame_word[CODE_W +: AW];
      cmd_data <= frame_word[CODE_W-1:0];
    end
  end

  always_comb begin
    cur_sel = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (cmd_addr == AW'(i)) cur_sel = cur_codes[i*FINE_W +: FINE_W];
  end

  always_comb begin
    unique case (cmd_op)
      OP_LOAD: wr_data = coarse_to_fine(cmd_data);
      OP_UP:   wr_data = step_up(cur_sel, cmd_data[STEP_W-1:0]);
      OP_DOWN: wr_data = step_down(cur_sel, cmd_data[STEP_W-1:0]);
      default: wr_data = cur_sel;
    endcase
  end

  assign wr_en   = tmr_done;
  assign wr_addr = cmd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_stb  <= 1'b0;
      upd_chan <= '0;
    end else begin
      upd_stb <= tmr_done;
      if (tmr_done) upd_chan <= cmd_addr;
    end
  end
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank #(
  parameter int NUM_CH = 16,
  parameter int AW     = 4,
  parameter int FINE_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [FINE_W-1:0]        wr_data,
  output logic [NUM_CH*FINE_W-1:0] codes
);
  localparam logic [FINE_W-1:0] MID_CODE = FINE_W'(1) << (FINE_W - 1);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [FINE_W-1:0] code_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                              code_q <= MID_CODE;
      else if (wr_en && (wr_addr == AW'(g)))   code_q <= wr_data;
    end
    assign codes[g*FINE_W +: FINE_W] = code_q;
  end
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl #(
  parameter int NUM_CH       = 16,
  parameter int CODE_W       = 12,
  parameter int FRAC_W       = 2,
  parameter int STEP_W       = 7,
  parameter int WRITE_CYCLES = 2500,
  parameter int STEP_CYCLES  = 100
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 sclk,
  input  logic                                 din,
  input  logic                                 sync_n,
  output logic                                 busy_n,
  output logic                                 upd_stb,
  output logic [$clog2(NUM_CH)-1:0]            upd_chan,
  output logic [NUM_CH*(CODE_W+FRAC_W)-1:0]    chan_codes
);
  localparam int AW         = $clog2(NUM_CH);
  localparam int FINE_W     = CODE_W + FRAC_W;
  localparam int FRAME_BITS = dac_cmd_pkg::OP_W + AW + CODE_W;
  localparam int LONGEST    = (WRITE_CYCLES > STEP_CYCLES) ? WRITE_CYCLES : STEP_CYCLES;
  localparam int TMR_W      = $clog2(LONGEST + 1);

  logic                  frame_ok;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  cmd_start;
  logic [TMR_W-1:0]      cmd_len;
  logic                  tmr_busy;
  logic                  tmr_done;
  logic                  wr_en;
  logic [AW-1:0]         wr_addr;
  logic [FINE_W-1:0]     wr_data;

  assign busy_n = !tmr_busy;

  dac_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .sync_n(sync_n),
    .lock(tmr_busy), .frame_ok(frame_ok), .frame_word(frame_word)
  );

  dac_cmd_exec #(
    .NUM_CH(NUM_CH), .AW(AW), .CODE_W(CODE_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W),
    .FRAME_BITS(FRAME_BITS), .TMR_W(TMR_W),
    .WRITE_CYCLES(WRITE_CYCLES), .STEP_CYCLES(STEP_CYCLES)
  ) u_exec (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_word(frame_word),
    .cur_codes(chan_codes), .tmr_done(tmr_done), .cmd_start(cmd_start),
    .cmd_len(cmd_len), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_stb(upd_stb), .upd_chan(upd_chan)
  );

  dac_busy_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .len(cmd_len),
    .busy(tmr_busy), .done(tmr_done)
  );

  dac_code_bank #(.NUM_CH(NUM_CH), .AW(AW), .FINE_W(FINE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .codes(chan_codes)
  );
endmodule

// File: rtl/dac_cmd_ctrl_chk.sv
module dac_cmd_ctrl_chk #(
  parameter int CODES_W = 224
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy_n,
  input logic               upd_stb,
  input logic [CODES_W-1:0] chan_codes,
  input logic               frame_ok,
  input logic [1:0]         frame_op,
  input logic               cmd_start
);
  // R6: busy only begins after a command was started
  a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(cmd_start));

  // R7: the strobe coincides with busy being released
  a_r7_stb_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $rose(busy_n));

  // R7: codes move only with the strobe
  a_r7_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> $stable(chan_codes));

  // R8: the idle operation leaves busy high
  a_r8_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && frame_op == 2'b11) |=> busy_n);

  // R9: no frame is accepted while an update is running
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !frame_ok);

  // R2: a command starts only from an accepted frame
  a_r2_start_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> frame_ok);
endmodule

bind dac_cmd_ctrl dac_cmd_ctrl_chk #(.CODES_W(NUM_CH*FINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .upd_stb(upd_stb),
  .chan_codes(chan_codes), .frame_ok(frame_ok),
  .frame_op(frame_word[FRAME_BITS-1 -: 2]), .cmd_start(cmd_start)
);

// File: tb/dac_cmd_ctrl_bench.sv
module dac_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 16;
  localparam int WCYC  = 20;
  localparam int SCYC  = 5;
  localparam int FW    = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic sync_n = 1'b1;
  logic busy_n;
  logic upd_stb;
  logic [3:0] upd_chan;
  logic [NCH*FW-1:0] chan_codes;

  int checks = 0;
  int errors = 0;
  int exp_code [NCH];
  int stb_cnt = 0;
  int stb_chan = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_cmd_ctrl #(.WRITE_CYCLES(WCYC), .STEP_CYCLES(SCYC)) u_dac_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .sync_n(sync_n),
    .busy_n(busy_n), .upd_stb(upd_stb), .upd_chan(upd_chan), .chan_codes(chan_codes)
  );

  always @(negedge clk) if (rst_n && upd_stb) begin
    stb_cnt++;
    stb_chan = int'(upd_chan);
  end

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int code_of(input int ch);
    return int'(chan_codes[ch*FW +: FW]);
  endfunction

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) chk(code_of(c), exp_code[c], req);
  endtask

  task automatic send_frame(input logic [17:0] w, input int nedges);
    @(negedge clk) sync_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nedges; i++) begin
      din  = (i < 18) ? w[17-i] : 1'b0;
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    sync_n = 1'b1;
  endtask

  // sends a frame and returns the busy-low cycle count and strobes seen
  task automatic run_cmd(input logic [17:0] w, output int busy_len, output int stbs);
    int s0;
    s0 = stb_cnt;
    send_frame(w, 18);
    busy_len = 0;
    repeat (WCYC + 10) begin
      @(negedge clk);
      if (!busy_n) busy_len++;
    end
    stbs = stb_cnt - s0;
  endtask

  function automatic int model_up(input int cur, input int s);
    return (cur + s > 16383) ? 16383 : cur + s;
  endfunction

  function automatic int model_down(input int cur, input int s);
    return (cur < s) ? 0 : cur - s;
  endfunction

  task automatic do_load(input int ch, input int c12);
    int bl, ns;
    run_cmd({2'b00, 4'(ch), 12'(c12)}, bl, ns);
    exp_code[ch] = c12 * 4;
    chk(bl, WCYC, "R6 load busy length");
    chk(ns, 1, "R7 strobe count");
    chk(stb_chan, ch, "R7 strobe channel");
    check_all("R3 load");
  endtask

  task automatic do_step(input int ch, input bit up, input int opnd, input string req);
    int bl, ns, s;
    s = opnd & 127;
    run_cmd({up ? 2'b01 : 2'b10, 4'(ch), 12'(opnd)}, bl, ns);
    exp_code[ch] = up ? model_up(exp_code[ch], s) : model_down(exp_code[ch], s);
    chk(bl, SCYC, "R6 step busy length");
    chk(ns, 1, "R7 strobe count");
    check_all(req);
  endtask

  task automatic expect_ignored(input logic [17:0] w, input int nedges, input string req);
    int bl, s0;
    s0 = stb_cnt;
    send_frame(w, nedges);
    bl = 0;
    repeat (WCYC + 10) begin
      @(negedge clk);
      if (!busy_n) bl++;
    end
    chk(bl, 0, req);
    chk(stb_cnt - s0, 0, req);
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) exp_code[c] = 'h2000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_all("R1 reset code");
    chk(int'(busy_n), 1, "R1 busy idle");
    chk(int'(upd_stb), 0, "R1 strobe idle");

    // R3/R2 sweep: every channel, distinct codes including both ends
    for (int c = 0; c < NCH; c++) begin
      int v;
      v = (c == 0) ? 0 : (c == NCH-1) ? 'hFFF : ((c * 'h123 + 'h45) & 'hFFF);
      do_load(c, v);
    end
    do_load(6, 'h800);

    // R4 increments, including disregarded upper operand bits
    do_step(6, 1'b1, 1, "R4 step 1");
    do_step(6, 1'b1, 10, "R4 step 10");
    do_step(6, 1'b1, 127, "R4 step 127");
    do_step(6, 1'b1, 'hF80 | 3, "R4 upper bits disregarded");
    // R5 decrements
    do_step(6, 1'b0, 64, "R5 step 64");
    do_step(6, 1'b0, 'hA80 | 7, "R5 upper bits disregarded");
    // R4 saturation at top, R5 saturation at bottom
    do_step(15, 1'b1, 127, "R4 saturate top");
    do_step(15, 1'b1, 1, "R4 stay at top");
    do_step(0, 1'b0, 5, "R5 saturate bottom");
    do_step(0, 1'b1, 2, "R4 up from zero");
    do_step(0, 1'b0, 127, "R5 clamp to zero");

    // R8 idle operation
    expect_ignored({2'b11, 4'd3, 12'hABC}, 18, "R8 no-op");
    // R10 wrong edge counts
    expect_ignored({2'b00, 4'd4, 12'h111}, 17, "R10 short frame");
    expect_ignored({2'b00, 4'd4, 12'h111}, 19, "R10 long frame");

    // R9 lockout: a second frame that overlaps busy is lost
    send_frame({2'b00, 4'd3, 12'h123}, 18);
    send_frame({2'b00, 4'd3, 12'hABC}, 18);
    exp_code[3] = 'h123 * 4;
    repeat (WCYC + 20) @(negedge clk);
    chk(int'(busy_n), 1, "R9 busy released");
    check_all("R9 overlapped frame ignored");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule